// File: doc/BRIEF.md
# 8-bit Add/Subtract Unit with Carry Flags

This block is the arithmetic half of the execution stage in a small 8-bit CPU core. It takes an accumulator operand and a second operand, plus the stored carry flag. It returns an 8-bit result and four status flags: zero, subtract, half-carry and carry. A 2-bit select chooses among four operations: plain add, add with carry, plain subtract and subtract with borrow. The unit is purely combinational. Sequencing, register write-back and flag storage belong to the surrounding core.

The incoming carry or borrow is never folded into the 8-bit second operand. Doing that would wrap an operand of 0xFF to 0x00 and lose the carry-out. Instead, the sum or difference is formed one bit wider than the data, with the carry-in as a separate one-bit term. The per-bit carry vector is then recovered as the exclusive-OR of that wide result with both zero-extended operands. Half-carry is read from bit 4 of this vector and carry from bit 8. The same identity yields the borrow vector for subtraction.

Top module: `alu8_arith`

## Requirements
- R1: With op_sel = 2'b00 (add), result equals (A + B) mod 256, and carry_in has no effect on any output.
- R2: With op_sel = 2'b01 (add with carry), result equals (A + B + carry_in) mod 256.
- R3: For both add operations, flag_carry is 1 exactly when A + B + c exceeds 255, where c is carry_in for 2'b01 and 0 for 2'b00. This holds when B = 0xFF and carry_in = 1.
- R4: For both add operations, flag_half is 1 exactly when A[3:0] + B[3:0] + c exceeds 15. This holds when B[3:0] = 0xF and carry_in = 1.
- R5: With op_sel = 2'b10 (subtract), result equals (A - B) mod 256 and carry_in has no effect. With op_sel = 2'b11 (subtract with borrow), result equals (A - B - carry_in) mod 256.
- R6: For both subtract operations, flag_carry is 1 exactly when A < B + c, and flag_half is 1 exactly when A[3:0] < B[3:0] + c. Here c is carry_in for 2'b11 and 0 for 2'b10.
- R7: flag_zero is 1 exactly when the 8-bit result is 0x00.
- R8: flag_sub is 0 for both add operations and 1 for both subtract operations.
- R9: flags_byte carries zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4. Bits 3..0 are always 0.
- R10: Add with carry of A = 0x01 and B = 0xFE gives result 0x00 and flags_byte 0xB0 when carry_in = 1. The same operation gives result 0xFF and flags_byte 0x00 when carry_in = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation: 00 add, 01 add with carry, 10 subtract, 11 subtract with borrow |
| opnd_a | input | 8 | Accumulator operand |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Stored carry flag, used as carry or borrow by 01 and 11 |
| result | output | 8 | Arithmetic result |
| flag_zero | output | 1 | Result is zero |
| flag_sub | output | 1 | Last operation was a subtraction |
| flag_half | output | 1 | Carry or borrow across the low nibble |
| flag_carry | output | 1 | Carry or borrow out of the full byte |
| flags_byte | output | 8 | The four flags packed into the upper nibble |

## Verification
Two functions can coincide in one evaluation: the carry-in term and the operand-boundary carry. This happens when B = 0xFF, or B's low nibble is 0xF, while carry_in = 1. In that case the carry-in alone produces both half-carry and carry, and the result may also wrap to zero. The bench provokes this overlap exhaustively for add with carry, across every operand pair and both carry values. It also aims directed vectors at the same boundaries for subtract with borrow. Every output is judged against an integer model that computes the carry and borrow conditions directly from the arithmetic definitions.

// File: rtl/alu8_pkg.sv
// Shared types for the 8-bit add/subtract unit.
// Assumes a 2-bit operation select and a four-flag status nibble.
package alu8_pkg;

    // Operation select encoding; bit 1 marks subtraction, bit 0 marks carry use
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_ADC = 2'b01,
        OP_SUB = 2'b10,
        OP_SBC = 2'b11
    } alu_op_e;

    // Status flags in the order they are packed into the flag byte
    typedef struct packed {
        logic zero;
        logic sub;
        logic half;
        logic carry;
    } alu_flags_t;

endpackage

// File: rtl/alu8_carry_sel.sv
// Decodes the operation select into a direction bit and the effective
// carry-in. Assumes op bit 1 selects subtraction and op bit 0 enables the
// stored carry; the stored carry is dropped for the plain operations.
module alu8_carry_sel
    import alu8_pkg::*;
(
    input  logic [1:0] op_sel,
    input  logic       carry_in,
    output logic       is_sub,
    output logic       cin_eff
);

    alu_op_e op;

    // Decode direction and gate the stored carry
    always_comb begin
        op      = alu_op_e'(op_sel);
        is_sub  = (op == OP_SUB) || (op == OP_SBC);
        cin_eff = ((op == OP_ADC) || (op == OP_SBC)) ? carry_in : 1'b0;
    end

endmodule

// File: rtl/alu8_wide_sum.sv
// Forms the sum or difference one bit wider than the data, with the carry-in
// as a separate term so the operand never wraps. It also recovers the per-bit
// carry (or borrow) vector as wide_result ^ a ^ b.
// Assumes unsigned operands, zero-extended by one bit.
module alu8_wide_sum #(
    parameter int DATA_W = 8
) (
    input  logic              is_sub,
    input  logic              cin_eff,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W:0]   wide_res,
    output logic [DATA_W:0]   carry_vec
);

    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] ext_a;
    logic [EXT_W-1:0] ext_b;
    logic [EXT_W-1:0] ext_c;

    // Zero-extend both operands and the carry term to the wide width
    always_comb begin
        ext_a = {1'b0, opnd_a};
        ext_b = {1'b0, opnd_b};
        ext_c = {{DATA_W{1'b0}}, cin_eff};
    end

    // Wide add or subtract, then the carry/borrow vector
    always_comb begin
        if (is_sub) begin
            wide_res = ext_a - ext_b - ext_c;
        end else begin
            wide_res = ext_a + ext_b + ext_c;
        end
        carry_vec = wide_res ^ ext_a ^ ext_b;
    end

endmodule

// File: rtl/alu8_flag_gen.sv
// Derives the result byte and the four status flags from the wide result and
// the carry vector, and packs them into the upper nibble of a flag byte.
// Assumes DATA_W is even, so that the half-carry sits at bit DATA_W/2.
module alu8_flag_gen
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              is_sub,
    input  logic [DATA_W:0]   wide_res,
    input  logic [DATA_W:0]   carry_vec,
    output logic [DATA_W-1:0] result,
    output alu_flags_t        flags,
    output logic [7:0]        flags_byte
);

    localparam int HALF_POS = DATA_W / 2;

    // Result byte and flag extraction
    always_comb begin
        result      = wide_res[DATA_W-1:0];
        flags.zero  = ~|wide_res[DATA_W-1:0];
        flags.sub   = is_sub;
        flags.half  = carry_vec[HALF_POS];
        flags.carry = carry_vec[DATA_W];
    end

    // Pack flags into bits 7..4, low nibble zero
    always_comb begin
        flags_byte = {flags, 4'b0000};
    end

endmodule

// File: rtl/alu8_arith.sv
// Top of the 8-bit add/subtract unit: add, add with carry, subtract and
// subtract with borrow, with zero, subtract, half-carry and carry flags.
// Purely combinational; assumes the core samples the outputs on its own clock.
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              flag_zero,
    output logic              flag_sub,
    output logic              flag_half,
    output logic              flag_carry,
    output logic [7:0]        flags_byte
);

    logic            is_sub;
    logic            cin_eff;
    logic [DATA_W:0] wide_res;
    logic [DATA_W:0] carry_vec;
    alu_flags_t      flags;

    alu8_carry_sel u_csel (
        .op_sel   (op_sel),
        .carry_in (carry_in),
        .is_sub   (is_sub),
        .cin_eff  (cin_eff)
    );

    alu8_wide_sum #(.DATA_W(DATA_W)) u_sum (
        .is_sub    (is_sub),
        .cin_eff   (cin_eff),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .wide_res  (wide_res),
        .carry_vec (carry_vec)
    );

    alu8_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .is_sub     (is_sub),
        .wide_res   (wide_res),
        .carry_vec  (carry_vec),
        .result     (result),
        .flags      (flags),
        .flags_byte (flags_byte)
    );

    // Break the flag struct out to individual ports
    always_comb begin
        flag_zero  = flags.zero;
        flag_sub   = flags.sub;
        flag_half  = flags.half;
        flag_carry = flags.carry;
    end

endmodule

// File: rtl/alu8_arith_chk.sv
// Checker for the add/subtract unit. It evaluates combinational immediate
// assertions whenever the ports change, once all inputs are known.
module alu8_arith_chk (
    input logic [1:0] op_sel,
    input logic [7:0] opnd_a,
    input logic [7:0] opnd_b,
    input logic       carry_in,
    input logic [7:0] result,
    input logic       flag_zero,
    input logic       flag_sub,
    input logic       flag_half,
    input logic       flag_carry,
    input logic [7:0] flags_byte
);

    logic [8:0] ref_sum;
    logic [4:0] ref_nib;

    // Independent wide sums for the plain add operation
    always_comb begin
        ref_sum = {1'b0, opnd_a} + {1'b0, opnd_b};
        ref_nib = {1'b0, opnd_a[3:0]} + {1'b0, opnd_b[3:0]};
    end

    // Port-level property checks
    always_comb begin
        if (!$isunknown({op_sel, opnd_a, opnd_b, carry_in})) begin
            // R7
            zero_flag_chk: assert (flag_zero == (result == 8'h00));
            // R8
            sub_flag_chk: assert (flag_sub == op_sel[1]);
            // R9
            flag_pack_chk: assert (flags_byte == {flag_zero, flag_sub, flag_half, flag_carry, 4'b0000});
            if (op_sel == 2'b00) begin
                // R1
                add_result_chk: assert (result == ref_sum[7:0]);
                // R3
                add_carry_chk: assert (flag_carry == ref_sum[8]);
                // R4
                add_half_chk: assert (flag_half == ref_nib[4]);
            end
            if (op_sel == 2'b10) begin
                // R6
                sub_carry_chk: assert (flag_carry == (opnd_a < opnd_b));
            end
        end
    end

endmodule

bind alu8_arith alu8_arith_chk u_chk (
    .op_sel     (op_sel),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .carry_in   (carry_in),
    .result     (result),
    .flag_zero  (flag_zero),
    .flag_sub   (flag_sub),
    .flag_half  (flag_half),
    .flag_carry (flag_carry),
    .flags_byte (flags_byte)
);

// File: tb/tb_alu8_arith.sv
// Testbench for alu8_arith: an exhaustive sweep of add with carry, random
// vectors for every operation, and directed corner cases, all judged
// against an integer reference model.
module tb_alu8_arith;

    logic       clk;
    logic [1:0] op_sel;
    logic [7:0] opnd_a;
    logic [7:0] opnd_b;
    logic       carry_in;
    logic [7:0] result;
    logic       flag_zero;
    logic       flag_sub;
    logic       flag_half;
    logic       flag_carry;
    logic [7:0] flags_byte;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 0;

    alu8_arith dut (
        .op_sel     (op_sel),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .carry_in   (carry_in),
        .result     (result),
        .flag_zero  (flag_zero),
        .flag_sub   (flag_sub),
        .flag_half  (flag_half),
        .flag_carry (flag_carry),
        .flags_byte (flags_byte)
    );

    // 125 MHz clock paces the vectors
    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Compare one value and log a failure
    task automatic cmp(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Apply one vector at the falling edge, then judge it 2 ns later
    task automatic run_vec(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b, input logic c);
        int ce, full, nib, exp_res, exp_c, exp_h, exp_z;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; carry_in = c;
        #2;
        ce = op[0] ? int'(c) : 0;
        if (!op[1]) begin
            full  = int'(a) + int'(b) + ce;
            nib   = int'(a[3:0]) + int'(b[3:0]) + ce;
            exp_c = (full > 255) ? 1 : 0;
            exp_h = (nib > 15) ? 1 : 0;
        end else begin
            full  = int'(a) - int'(b) - ce;
            nib   = int'(a[3:0]) - int'(b[3:0]) - ce;
            exp_c = (full < 0) ? 1 : 0;
            exp_h = (nib < 0) ? 1 : 0;
        end
        exp_res = full & 255;
        exp_z   = (exp_res == 0) ? 1 : 0;
        case (op)
            2'b00:   cmp("R1 result", result, exp_res);
            2'b01:   cmp("R2 result", result, exp_res);
            default: cmp("R5 result", result, exp_res);
        endcase
        if (!op[1]) begin
            cmp("R3 carry", flag_carry, exp_c);
            cmp("R4 half", flag_half, exp_h);
        end else begin
            cmp("R6 carry", flag_carry, exp_c);
            cmp("R6 half", flag_half, exp_h);
        end
        cmp("R7 zero", flag_zero, exp_z);
        cmp("R8 sub", flag_sub, int'(op[1]));
        cmp("R9 byte", flags_byte, (exp_z << 7) | (int'(op[1]) << 6) | (exp_h << 5) | (exp_c << 4));
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Stimulus sequence
    initial begin
        int seed;
        seed = 32'h5eed_0a1b;
        void'($urandom(seed));
        op_sel = 2'b00; opnd_a = 8'h00; opnd_b = 8'h00; carry_in = 1'b0;
        #2;
        // Idle state: all-zero inputs give result 0 with only zero set (R7)
        cmp("R7 idle result", result, 0);
        cmp("R7 idle flags", flags_byte, 8'h80);

        // R10 directed examples
        run_vec(2'b01, 8'h01, 8'hFE, 1'b1);
        cmp("R10 result cin=1", result, 8'h00);
        cmp("R10 flags cin=1", flags_byte, 8'hB0);
        run_vec(2'b01, 8'h01, 8'hFE, 1'b0);
        cmp("R10 result cin=0", result, 8'hFF);
        cmp("R10 flags cin=0", flags_byte, 8'h00);

        // R3/R4 boundary: B = FF or low nibble F with carry set
        run_vec(2'b01, 8'h00, 8'hFF, 1'b1);
        run_vec(2'b01, 8'h80, 8'h7F, 1'b1);
        run_vec(2'b01, 8'h10, 8'h0F, 1'b1);
        // R1/R5: carry_in ignored on the plain operations
        run_vec(2'b00, 8'h00, 8'hFF, 1'b1);
        run_vec(2'b10, 8'h05, 8'h05, 1'b1);
        // R6 borrow boundaries
        run_vec(2'b11, 8'h00, 8'hFF, 1'b1);
        run_vec(2'b11, 8'h10, 8'h0F, 1'b1);
        run_vec(2'b11, 8'h00, 8'h00, 1'b1);
        run_vec(2'b10, 8'h00, 8'h01, 1'b0);

        // Exhaustive add with carry over all operands and both carries (R2, R3, R4)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                for (int c = 0; c < 2; c++) begin
                    run_vec(2'b01, a[7:0], b[7:0], c[0]);
                end
            end
        end

        // Random vectors on every operation (R1, R5, R6, R8, R9)
        for (int i = 0; i < 20000; i++) begin
            logic [31:0] r;
            r = $urandom();
            run_vec(r[1:0], r[9:2], r[17:10], r[18]);
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule